// File: doc/BRIEF.md
# Dual-Channel Temperature Conversion Sequencer

This block decides when temperature conversions happen for two sensing channels, an on-die sensor (local) and an external diode (remote). It pulls digitized 8-bit two's complement samples from a converter port and takes 16 samples from the local channel, then 16 from the remote channel. For each channel it stores the floor of the mean of those 16 samples in a value register, with one LSB equal to 1 °C. After each store it gives the limit-checking logic a one-cycle update pulse.

Conversions are paced by an 8-bit rate register. The three low bits of that register choose a period of `TICK_DIV * 2^(7-code)` clock cycles, where `TICK_DIV` is the number of cycles in one eighth of a second. Any code above 7 behaves like code 7. The block stops converting in either of two standby cases: the run pin is low, or the software sleep bit is set. Entering standby drops the conversion in progress, and neither value register is written. In software sleep with the run pin high, a one-shot write runs one complete two-channel conversion and the block then goes back to sleep. The open-circuit comparator input is captured once, when each conversion starts.

The sample port uses valid/ready. A sample transfers only on a cycle where `smp_valid` and `smp_ready` are both high. `smp_ready` is high only while a conversion is measuring. It is low while idle and during the cycle in which standby aborts a conversion. While ready is low the converter must hold its sample. Valid may drop at any time without corrupting the average. `ch_sel` tells the converter which channel to digitize next.

Top module: `tsq_conv_seq`

## Requirements
- R1: Reset state: both value registers are 00h, the rate register is 02h, and `busy`, `open_fault` and both update pulses are low.
- R2: A conversion measures the local channel first (`ch_sel`=0) and then the remote channel (`ch_sel`=1). `busy` is high from the start of a conversion until the cycle after the remote result is stored.
- R3: Each stored result is floor((sum of the 16 accepted 8-bit two's complement samples) / 16), kept as an 8-bit two's complement value.
- R4: A sample is consumed only when `smp_valid` and `smp_ready` are both high, and `smp_ready` is high only while `busy` is high. Each channel consumes exactly 16 samples, however valid is gapped.
- R5: After each value-register write, that channel's update pulse is high for exactly one cycle. A value register changes only together with its pulse, and the two pulses are never high in the same cycle.
- R6: When the block is free, consecutive conversion starts are `TICK_DIV * 2^(7-c)` cycles apart, where c = rate code[2:0]. A code of 08h–FFh acts as c=7. A write stores all 8 bits, which read back on `rate_q`. The default code 02h gives `TICK_DIV*32` cycles.
- R7: While `run_pin` is low, a conversion in progress ends on the next cycle without writing its value register. No conversion starts, and one-shot writes are ignored.
- R8: While `cfg_sleep` is 1, a periodic conversion in progress is dropped without writing its value register, and no periodic conversion starts.
- R9: With `cfg_sleep`=1 and `run_pin`=1, a one-shot write while idle starts exactly one full two-channel conversion. The block then stays idle.
- R10: `open_fault` takes the value of `open_cmp` at each conversion start and holds it until the next start.
- R11: When both standby sources release, a conversion starts on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_pin | input | 1 | Hardware run request; low forces full standby |
| cfg_sleep | input | 1 | Software sleep bit; 1 selects standby that still accepts one-shot |
| oneshot_wr | input | 1 | One-cycle strobe from a one-shot register write |
| rate_wr | input | 1 | One-cycle write strobe for the rate register |
| rate_wdata | input | 8 | Rate register write data |
| rate_q | output | 8 | Rate register contents |
| open_cmp | input | 1 | Remote open-circuit comparator output |
| open_fault | output | 1 | Comparator value captured at last conversion start |
| smp_valid | input | 1 | Converter sample valid |
| smp_ready | output | 1 | Sequencer ready to consume a sample |
| smp_data | input | 8 | Signed sample, 1 °C per LSB |
| ch_sel | output | 1 | Channel to convert: 0 local, 1 remote |
| busy | output | 1 | Conversion in progress |
| local_temp | output | 8 | Local value register |
| remote_temp | output | 8 | Remote value register |
| local_upd | output | 1 | One-cycle pulse after local value write |
| remote_upd | output | 1 | One-cycle pulse after remote value write |

## Verification
The bound checker watches a set of rules on every cycle. Update pulses last one cycle and never coincide, and a value register never changes without its pulse. Ready implies busy. A low run pin leaves the block idle on the next cycle. Software sleep never starts a conversion except on a one-shot write. The captured open flag and the rate register stay stable between their own events. Other behaviour shows up only in the bench's directed scenarios: the averaging arithmetic on negative and extreme values, the local-then-remote order, the exact start spacing for several rate codes including a reserved one, the fact that aborted conversions leave no trace, and the single conversion a one-shot produces.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_MEAS = 1'b1} seq_state_e;
  typedef enum logic {CH_LOCAL = 1'b0, CH_REMOTE = 1'b1} chan_e;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/tsq_rate_pacer.sv
// Holds the rate code and raises 'due' once a full period has elapsed.
module tsq_rate_pacer #(
  parameter int unsigned TICK_DIV = 12500000,
  parameter int unsigned RATE_TOP = 7,
  parameter int unsigned RATE_W   = 8,
  parameter int unsigned RATE_RST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_wdata,
  output logic [RATE_W-1:0] rate_q,
  output logic              due
);
  localparam int unsigned PRE_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned PER_W  = RATE_TOP + 1;
  localparam int unsigned CODE_W = (RATE_TOP > 0) ? $clog2(RATE_TOP + 1) : 1;

  logic [RATE_W-1:0] rate_r;
  logic [PRE_W-1:0]  pre;
  logic [PER_W-1:0]  per;
  logic              due_q;
  logic [CODE_W-1:0] eff_code;
  logic [CODE_W-1:0] shamt;
  logic [PER_W-1:0]  period_m1;
  logic              tick;
  logic              hit;

  always_comb begin
    if (rate_r > RATE_W'(RATE_TOP)) eff_code = CODE_W'(RATE_TOP);
    else                            eff_code = rate_r[CODE_W-1:0];
    shamt     = CODE_W'(RATE_TOP) - eff_code;
    period_m1 = (PER_W'(1) << shamt) - PER_W'(1);
    tick      = (pre == PRE_W'(TICK_DIV - 1));
    hit       = run && tick && (per >= period_m1);
  end

  assign due    = due_q || hit;
  assign rate_q = rate_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_r <= RATE_W'(RATE_RST);
      pre    <= '0;
      per    <= '0;
      due_q  <= 1'b1;
    end else begin
      if (rate_wr) rate_r <= rate_wdata;
      if (!run) begin
        pre   <= '0;
        per   <= '0;
        due_q <= 1'b1;
      end else if (restart) begin
        pre   <= '0;
        per   <= '0;
        due_q <= 1'b0;
      end else begin
        pre <= tick ? '0 : pre + PRE_W'(1);
        if (tick) per <= hit ? '0 : per + PER_W'(1);
        if (hit) due_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsq_avg_accum.sv
// Sums 2^AVG_LOG2 signed samples; 'avg' is the floored mean including din.
module tsq_avg_accum #(
  parameter int unsigned SMP_W    = 8,
  parameter int unsigned AVG_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [SMP_W-1:0] din,
  output logic [SMP_W-1:0] avg,
  output logic             last
);
  localparam int unsigned ACC_W = SMP_W + AVG_LOG2;

  logic [ACC_W-1:0]    acc;
  logic [ACC_W-1:0]    sum_nx;
  logic [AVG_LOG2-1:0] cnt;

  assign sum_nx = acc + {{AVG_LOG2{din[SMP_W-1]}}, din};
  assign avg    = sum_nx[ACC_W-1:AVG_LOG2];
  assign last   = (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc <= '0;
      cnt <= '0;
    end else if (take) begin
      if (last) begin
        acc <= '0;
        cnt <= '0;
      end else begin
        acc <= sum_nx;
        cnt <= cnt + AVG_LOG2'(1);
      end
    end
  end
endmodule

// File: rtl/tsq_value_bank.sv
// One value register and one update pulse per channel.
module tsq_value_bank #(
  parameter int unsigned SMP_W  = 8,
  parameter int unsigned NCH    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            wr_en,
  input  logic [SMP_W-1:0]          wdata,
  output logic [NCH-1:0][SMP_W-1:0] vals,
  output logic [NCH-1:0]            upd
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vals[i] <= '0;
        upd[i]  <= 1'b0;
      end else begin
        upd[i] <= wr_en[i];
        if (wr_en[i]) vals[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/tsq_conv_seq.sv
module tsq_conv_seq
  import tsq_pkg::*;
#(
  parameter int unsigned SMP_W    = 8,
  parameter int unsigned AVG_LOG2 = 4,
  parameter int unsigned TICK_DIV = 12500000,
  parameter int unsigned RATE_TOP = 7,
  parameter int unsigned RATE_W   = 8,
  parameter int unsigned RATE_RST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_pin,
  input  logic              cfg_sleep,
  input  logic              oneshot_wr,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_wdata,
  output logic [RATE_W-1:0] rate_q,
  input  logic              open_cmp,
  output logic              open_fault,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              ch_sel,
  output logic              busy,
  output logic [SMP_W-1:0]  local_temp,
  output logic [SMP_W-1:0]  remote_temp,
  output logic              local_upd,
  output logic              remote_upd
);
  seq_state_e st;
  chan_e      ch;
  logic       os_q;
  logic       open_q;
  logic       meas, abort, start_per, start_os, take, last, commit, due;
  logic [SMP_W-1:0]               avg;
  logic [NUM_CH-1:0]              wr_en;
  logic [NUM_CH-1:0]              upd;
  logic [NUM_CH-1:0][SMP_W-1:0]   vals;

  assign meas      = (st == SEQ_MEAS);
  assign abort     = meas && (!run_pin || (cfg_sleep && !os_q));
  assign start_per = !meas && run_pin && !cfg_sleep && due;
  assign start_os  = !meas && run_pin && cfg_sleep && oneshot_wr;
  assign smp_ready = meas && !abort;
  assign take      = smp_valid && smp_ready;
  assign commit    = take && last;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
    assign wr_en[i] = commit && (int'(ch) == i);
  end

  tsq_rate_pacer #(
    .TICK_DIV(TICK_DIV), .RATE_TOP(RATE_TOP), .RATE_W(RATE_W), .RATE_RST(RATE_RST)
  ) pacer_i (
    .clk(clk), .rst_n(rst_n), .run(run_pin && !cfg_sleep), .restart(start_per),
    .rate_wr(rate_wr), .rate_wdata(rate_wdata), .rate_q(rate_q), .due(due)
  );

  tsq_avg_accum #(.SMP_W(SMP_W), .AVG_LOG2(AVG_LOG2)) accum_i (
    .clk(clk), .rst_n(rst_n), .clr(abort || start_per || start_os),
    .take(take), .din(smp_data), .avg(avg), .last(last)
  );

  tsq_value_bank #(.SMP_W(SMP_W), .NCH(NUM_CH)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(avg), .vals(vals), .upd(upd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SEQ_IDLE;
      ch     <= CH_LOCAL;
      os_q   <= 1'b0;
      open_q <= 1'b0;
    end else if (abort) begin
      st   <= SEQ_IDLE;
      ch   <= CH_LOCAL;
      os_q <= 1'b0;
    end else if (start_per || start_os) begin
      st     <= SEQ_MEAS;
      ch     <= CH_LOCAL;
      os_q   <= start_os;
      open_q <= open_cmp;
    end else if (commit) begin
      if (ch == CH_LOCAL) begin
        ch <= CH_REMOTE;
      end else begin
        st   <= SEQ_IDLE;
        ch   <= CH_LOCAL;
        os_q <= 1'b0;
      end
    end
  end

  assign busy        = meas;
  assign ch_sel      = (ch == CH_REMOTE);
  assign open_fault  = open_q;
  assign local_temp  = vals[CH_LOCAL];
  assign remote_temp = vals[CH_REMOTE];
  assign local_upd   = upd[CH_LOCAL];
  assign remote_upd  = upd[CH_REMOTE];
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int unsigned SMP_W  = 8,
  parameter int unsigned RATE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_pin,
  input logic              cfg_sleep,
  input logic              oneshot_wr,
  input logic              rate_wr,
  input logic [RATE_W-1:0] rate_q,
  input logic              smp_ready,
  input logic              busy,
  input logic              open_fault,
  input logic [SMP_W-1:0]  local_temp,
  input logic [SMP_W-1:0]  remote_temp,
  input logic              local_upd,
  input logic              remote_upd
);
  assert_ready_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> busy);

  assert_upd_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({local_upd, remote_upd}));

  assert_lupd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    local_upd |=> !local_upd);

  assert_rupd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    remote_upd |=> !remote_upd);

  assert_lval_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (local_temp != $past(local_temp)) |-> local_upd);

  assert_rval_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_temp != $past(remote_temp)) |-> remote_upd);

  assert_upd_in_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (local_upd || remote_upd) |-> $past(busy));

  assert_pin_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_pin |=> !busy);

  assert_sleep_nostart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sleep && !busy && !oneshot_wr) |=> !busy);

  assert_open_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(open_fault));

  assert_rate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_wr |=> $stable(rate_q));
endmodule

bind tsq_conv_seq tsq_checker #(.SMP_W(SMP_W), .RATE_W(RATE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_pin(run_pin), .cfg_sleep(cfg_sleep),
  .oneshot_wr(oneshot_wr), .rate_wr(rate_wr), .rate_q(rate_q),
  .smp_ready(smp_ready), .busy(busy), .open_fault(open_fault),
  .local_temp(local_temp), .remote_temp(remote_temp),
  .local_upd(local_upd), .remote_upd(remote_upd)
);

// File: tb/tsq_conv_seq_tb_top.sv
module tsq_conv_seq_tb_top;
  localparam int TD = 40;

  logic clk, rst_n, run_pin, cfg_sleep, oneshot_wr, rate_wr, open_cmp, smp_valid;
  logic [7:0] rate_wdata, rate_q, smp_data, local_temp, remote_temp;
  logic open_fault, smp_ready, ch_sel, busy, local_upd, remote_upd;

  int checks = 0, errors = 0, cyc = 0;
  int rise_cnt = 0, lupd_cnt = 0, rupd_cnt = 0, hs_cnt = 0;
  bit pb = 0;
  int loc_src = 0, rem_src = 0, pat_org = 0;
  bit pat_on = 0, gap_on = 0, gap_t = 0;

  tsq_conv_seq #(.TICK_DIV(TD)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_pin(run_pin), .cfg_sleep(cfg_sleep),
    .oneshot_wr(oneshot_wr), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .rate_q(rate_q), .open_cmp(open_cmp), .open_fault(open_fault),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .ch_sel(ch_sel), .busy(busy), .local_temp(local_temp),
    .remote_temp(remote_temp), .local_upd(local_upd), .remote_upd(remote_upd)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Converter model: offset pattern i-8 for i = 0..15 when pat_on.
  always_comb begin
    int v;
    v = ch_sel ? rem_src : loc_src;
    if (pat_on) v = v + ((hs_cnt - pat_org) % 16) - 8;
    smp_data  = 8'(v);
    smp_valid = gap_on ? gap_t : 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (smp_valid && smp_ready) hs_cnt <= hs_cnt + 1;
  end

  always @(negedge clk) begin
    gap_t <= ~gap_t;
    if (busy && !pb) rise_cnt <= rise_cnt + 1;
    if (local_upd) lupd_cnt <= lupd_cnt + 1;
    if (remote_upd) rupd_cnt <= rupd_cnt + 1;
    pb <= busy;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int s8(input logic [7:0] x);
    return int'($signed(x));
  endfunction

  task automatic wait_rise(output int t);
    bit p;
    int n;
    p = busy; n = 0;
    forever begin
      @(negedge clk);
      if (busy && !p) break;
      p = busy; n++;
      if (n > 8000) begin chk("R6 start timeout", 0, 1); break; end
    end
    t = cyc;
  endtask

  task automatic wait_upd(input bit remote);
    int n;
    n = 0;
    forever begin
      @(negedge clk);
      if (remote ? remote_upd : local_upd) break;
      n++;
      if (n > 8000) begin chk("R5 update timeout", 0, 1); break; end
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; run_pin = 1; cfg_sleep = 0; oneshot_wr = 0; rate_wr = 0;
    rate_wdata = 0; open_cmp = 0; loc_src = 25; rem_src = -55;
    repeat (4) @(negedge clk);
    chk("R1 local reset", s8(local_temp), 0);
    chk("R1 remote reset", s8(remote_temp), 0);
    chk("R1 rate reset", int'(rate_q), 2);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 open reset", int'(open_fault), 0);
    chk("R1 pulses reset", int'({local_upd, remote_upd}), 0);
  endtask

  task automatic t_first_conv();
    int t0, t1;
    rst_n = 1;
    wait_rise(t0);
    chk("R2 local first", int'(ch_sel), 0);
    wait_upd(0);
    chk("R3 local avg const", s8(local_temp), 25);
    chk("R2 remote next", int'(ch_sel), 1);
    chk("R2 busy mid", int'(busy), 1);
    wait_upd(1);
    chk("R3 remote avg negative", s8(remote_temp), -55);
    chk("R2 busy ends", int'(busy), 0);
    wait_rise(t1);
    chk("R6 default period", t1 - t0, TD * 32);
  endtask

  task automatic t_pattern();
    wait_idle();
    pat_org = hs_cnt; pat_on = 1; loc_src = 40; rem_src = -20;
    wait_upd(1);
    chk("R3 local floor", s8(local_temp), 39);
    chk("R3 remote floor negative", s8(remote_temp), -21);
    wait_idle();
    pat_on = 0;
  endtask

  task automatic t_extremes();
    int t;
    loc_src = 127; rem_src = -128;
    wait_rise(t);
    wait_upd(1);
    chk("R3 max positive", s8(local_temp), 127);
    chk("R3 most negative", s8(remote_temp), -128);
  endtask

  task automatic t_gaps();
    int t, h0;
    wait_idle();
    gap_on = 1; loc_src = 10; rem_src = -3;
    wait_rise(t);
    h0 = hs_cnt;
    wait_upd(1);
    @(negedge clk);
    chk("R4 handshakes per conversion", hs_cnt - h0, 32);
    chk("R4 local with gaps", s8(local_temp), 10);
    chk("R4 remote with gaps", s8(remote_temp), -3);
    gap_on = 0;
  endtask

  task automatic wr_rate(input logic [7:0] v);
    wait_idle();
    rate_wdata = v; rate_wr = 1;
    @(negedge clk);
    rate_wr = 0;
    chk("R6 rate readback", int'(rate_q), int'(v));
  endtask

  task automatic t_rate();
    int t1, t2;
    wr_rate(8'h06);
    wait_rise(t1); wait_rise(t2);
    chk("R6 code 6 period", t2 - t1, TD * 2);
    wr_rate(8'h09);
    wait_rise(t1); wait_rise(t2);
    chk("R6 reserved code acts as 7", t2 - t1, TD);
    wr_rate(8'h00);
    wait_rise(t1); wait_rise(t2);
    chk("R6 code 0 period", t2 - t1, TD * 128);
    wr_rate(8'h06);
  endtask

  task automatic t_hw_stby();
    int t, r0, rc;
    loc_src = 5; rem_src = -7;
    wait_rise(t); wait_upd(1);
    wait_rise(t); wait_upd(0);
    r0 = s8(remote_temp);
    rem_src = 99;
    repeat (5) @(negedge clk);
    run_pin = 0;
    @(negedge clk);
    chk("R7 abort ends busy", int'(busy), 0);
    rc = rupd_cnt;
    cfg_sleep = 1;
    oneshot_wr = 1; @(negedge clk); oneshot_wr = 0;
    t = rise_cnt;
    repeat (500) @(negedge clk);
    chk("R7 no start, one-shot ignored", rise_cnt - t, 0);
    chk("R7 no remote commit", rupd_cnt - rc, 0);
    chk("R7 remote kept", s8(remote_temp), r0);
    cfg_sleep = 0; run_pin = 1;
    @(negedge clk);
    chk("R11 immediate start", int'(busy), 1);
    wait_upd(1);
    chk("R11 new remote", s8(remote_temp), 99);
  endtask

  task automatic t_sw_stby();
    int t, l0, r0, lc, rc, rs;
    wait_rise(t);
    repeat (3) @(negedge clk);
    cfg_sleep = 1;
    @(negedge clk);
    chk("R8 sleep aborts", int'(busy), 0);
    l0 = s8(local_temp); r0 = s8(remote_temp);
    lc = lupd_cnt; rc = rupd_cnt; rs = rise_cnt;
    loc_src = 60; rem_src = 61;
    repeat (1000) @(negedge clk);
    chk("R8 no periodic start", rise_cnt - rs, 0);
    chk("R8 no local commit", lupd_cnt - lc, 0);
    chk("R8 local kept", s8(local_temp), l0);
    chk("R8 remote kept", s8(remote_temp), r0);
    oneshot_wr = 1; @(negedge clk); oneshot_wr = 0;
    chk("R9 one-shot starts", int'(busy), 1);
    wait_upd(1);
    chk("R9 one-shot local", s8(local_temp), 60);
    chk("R9 one-shot remote", s8(remote_temp), 61);
    repeat (1000) @(negedge clk);
    chk("R9 single conversion", rise_cnt - rs, 1);
    chk("R9 back to idle", int'(busy), 0);
    cfg_sleep = 0;
  endtask

  task automatic t_open();
    int t;
    wait_idle();
    open_cmp = 1;
    wait_rise(t);
    chk("R10 fault captured", int'(open_fault), 1);
    open_cmp = 0;
    repeat (5) @(negedge clk);
    chk("R10 held during conversion", int'(open_fault), 1);
    wait_rise(t);
    chk("R10 cleared at next start", int'(open_fault), 0);
  endtask

  initial begin
    t_reset();
    t_first_conv();
    t_pattern();
    t_extremes();
    t_gaps();
    t_rate();
    t_hw_stby();
    t_sw_stby();
    t_open();
    repeat (10) @(negedge clk);
    summary();
  end
endmodule